// File: doc/BRIEF.md
# Modem Handshake Control Register with Diagnostic Loopback

This block holds the byte-wide control register that sets the four active-low modem handshake lines of a serial port. A host writes the register through a simple write strobe and reads it back combinationally. The four lower bits drive the handshake outputs. The fifth bit switches the port into a self-test loopback, where both the serial data path and the modem status path are closed inside the chip.

In normal operation the transmitter's shift output goes to the serial output pin. The serial input pin feeds the receiver. The four external active-low status inputs are inverted into active-high status flags for the rest of the port. In loopback the serial pin is held at the idle (high) level and the pin input is ignored. The transmitter's shift output feeds the receiver directly. The status flags come from the handshake bits of the register instead of the external pins, and the external handshake outputs rest at their inactive high level. The three upper register bits have no function and always read as zero.

Top module: `mdm_ctl_loop`

## Requirements
- R1: While reset is asserted and after it is released with no write, the register reads 0x00, all four handshake outputs are 1 and loopback is off.
- R2: A write with `wr_en` high updates the register at the next clock edge; `rd_data` then shows `wr_data[4:0]`, and bits 7 to 5 always read 0, whatever was written to them.
- R3: Outside loopback, `dtr_n` equals the inverse of register bit 0.
- R4: Outside loopback, `rts_n`, `out1_n` and `out2_n` equal the inverses of register bits 1, 2 and 3.
- R5: While register bit 4 is 1 (loopback), `sout` is 1 regardless of `tx_shift`.
- R6: Outside loopback, `sout` follows `tx_shift` and `rx_shift` follows `sin`.
- R7: In loopback, `rx_shift` follows `tx_shift` and `sin` has no effect on it.
- R8: Outside loopback, `dsr`, `cts`, `ri` and `dcd` are the inverses of `dsr_n`, `cts_n`, `ri_n` and `dcd_n`.
- R9: In loopback, `dsr`, `cts`, `ri` and `dcd` equal register bits 0, 1, 2 and 3 respectively, and the external status inputs have no effect.
- R10: In loopback, `dtr_n`, `rts_n`, `out1_n` and `out2_n` are all 1.
- R11: With `wr_en` low, the register value is unchanged across a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read data |
| dtr_n | output | 1 | Terminal-ready output, active low |
| rts_n | output | 1 | Request-to-send output, active low |
| out1_n | output | 1 | General output 1, active low |
| out2_n | output | 1 | General output 2, active low |
| dsr_n | input | 1 | External set-ready input, active low |
| cts_n | input | 1 | External clear-to-send input, active low |
| ri_n | input | 1 | External ring input, active low |
| dcd_n | input | 1 | External carrier-detect input, active low |
| dsr | output | 1 | Internal set-ready status, active high |
| cts | output | 1 | Internal clear-to-send status, active high |
| ri | output | 1 | Internal ring status, active high |
| dcd | output | 1 | Internal carrier-detect status, active high |
| sin | input | 1 | Serial input pin |
| sout | output | 1 | Serial output pin |
| tx_shift | input | 1 | Transmitter shift register output |
| rx_shift | output | 1 | Receiver shift register input |

## Verification
The bench builds the block with its default parameters: an 8-bit register with 5 live bits and 4 handshake lines. That width leaves three dead bits, so writes of all-ones and random bytes exercise the zero-read of the upper field. Random traffic toggles bit 4 often, so every mux is compared in both modes against random pin values. Every handshake and status pairing is seen at 0 and at 1 while loopback enters and leaves.

// File: rtl/mdm_ctl_pkg.sv
package mdm_ctl_pkg;

  localparam int unsigned HS_LINES = 4;

  typedef struct packed {
    logic       loop_en;
    logic [3:0] hs;      // [0] term-ready, [1] req-send, [2] gp1, [3] gp2
  } ctl_fields_t;

  function automatic logic [7:0] keep_live(input logic [7:0] d, input int unsigned live_w);
    logic [7:0] m;
    m = 8'((9'd1 << live_w) - 9'd1);
    return d & m;
  endfunction

  function automatic logic drive_low_active(input logic bit_on, input logic loop_en);
    return loop_en ? 1'b1 : ~bit_on;
  endfunction

  function automatic logic pick_status(input logic ext_n, input logic ctl_bit, input logic loop_en);
    return loop_en ? ctl_bit : ~ext_n;
  endfunction

endpackage

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg #(
  parameter int unsigned REG_W  = 8,
  parameter int unsigned LIVE_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data
);
  import mdm_ctl_pkg::*;

  logic [REG_W-1:0] reg_q;
  logic [REG_W-1:0] reg_next;

  always_comb begin
    reg_next = reg_q;
    if (wr_en) reg_next = keep_live(wr_data, LIVE_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= '0;
    else        reg_q <= reg_next;
  end

  assign rd_data = reg_q;

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[LIVE_W-1:0] == $past(wr_data[LIVE_W-1:0])) &&
              (rd_data[REG_W-1:LIVE_W] == '0));

  assert_hold_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));

endmodule

// File: rtl/mdm_hs_drive.sv
module mdm_hs_drive #(
  parameter int unsigned LINES = 4
) (
  input  logic             loop_en,
  input  logic [LINES-1:0] hs_bits,
  output logic [LINES-1:0] hs_out_n
);
  import mdm_ctl_pkg::*;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign hs_out_n[i] = drive_low_active(hs_bits[i], loop_en);
  end

endmodule

// File: rtl/mdm_status_sel.sv
module mdm_status_sel #(
  parameter int unsigned LINES = 4
) (
  input  logic             loop_en,
  input  logic [LINES-1:0] ext_n,
  input  logic [LINES-1:0] hs_bits,
  output logic [LINES-1:0] stat
);
  import mdm_ctl_pkg::*;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign stat[i] = pick_status(ext_n[i], hs_bits[i], loop_en);
  end

endmodule

// File: rtl/mdm_serial_sel.sv
module mdm_serial_sel (
  input  logic loop_en,
  input  logic sin,
  input  logic tx_shift,
  output logic sout,
  output logic rx_shift
);
  assign sout     = loop_en ? 1'b1 : tx_shift;
  assign rx_shift = loop_en ? tx_shift : sin;
endmodule

// File: rtl/mdm_ctl_loop.sv
module mdm_ctl_loop #(
  parameter int unsigned REG_W  = 8,
  parameter int unsigned LINES  = mdm_ctl_pkg::HS_LINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             dtr_n,
  output logic             rts_n,
  output logic             out1_n,
  output logic             out2_n,
  input  logic             dsr_n,
  input  logic             cts_n,
  input  logic             ri_n,
  input  logic             dcd_n,
  output logic             dsr,
  output logic             cts,
  output logic             ri,
  output logic             dcd,
  input  logic             sin,
  output logic             sout,
  input  logic             tx_shift,
  output logic             rx_shift
);
  localparam int unsigned LOOP_BIT = LINES;
  localparam int unsigned LIVE_W   = LINES + 1;

  logic [REG_W-1:0] reg_val;
  logic             loop_en;
  logic [LINES-1:0] hs_bits;
  logic [LINES-1:0] hs_out_n;
  logic [LINES-1:0] ext_n;
  logic [LINES-1:0] stat;

  mdm_ctl_reg #(.REG_W(REG_W), .LIVE_W(LIVE_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(reg_val)
  );

  assign rd_data = reg_val;
  assign loop_en = reg_val[LOOP_BIT];
  assign hs_bits = reg_val[LINES-1:0];

  mdm_hs_drive #(.LINES(LINES)) u_drv (
    .loop_en(loop_en), .hs_bits(hs_bits), .hs_out_n(hs_out_n)
  );

  assign ext_n = {dcd_n, ri_n, cts_n, dsr_n};

  mdm_status_sel #(.LINES(LINES)) u_stat (
    .loop_en(loop_en), .ext_n(ext_n), .hs_bits(hs_bits), .stat(stat)
  );

  mdm_serial_sel u_ser (
    .loop_en(loop_en), .sin(sin), .tx_shift(tx_shift), .sout(sout), .rx_shift(rx_shift)
  );

  assign dtr_n  = hs_out_n[0];
  assign rts_n  = hs_out_n[1];
  assign out1_n = hs_out_n[2];
  assign out2_n = hs_out_n[3];
  assign dsr    = stat[0];
  assign cts    = stat[1];
  assign ri     = stat[2];
  assign dcd    = stat[3];

  assert_loop_sout_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] |-> sout);

  assert_loop_rx_from_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] |-> (rx_shift == tx_shift));

  assert_loop_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] |-> ({dcd, ri, cts, dsr} == rd_data[3:0]));

  assert_loop_outs_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] |-> ({dtr_n, rts_n, out1_n, out2_n} == 4'hF));

  assert_normal_dtr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[4] |-> (dtr_n != rd_data[0]));

endmodule

// File: tb/mdm_ctl_loop_tb.sv
module mdm_ctl_loop_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       dtr_n, rts_n, out1_n, out2_n;
  logic       dsr_n = 1'b1, cts_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic       dsr, cts, ri, dcd;
  logic       sin = 1'b1, sout, tx_shift = 1'b1, rx_shift;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // model state
  logic [7:0] m_reg = 8'h00;
  logic       prev_wr = 1'b0;
  logic [7:0] prev_data = 8'h00;

  always #4 clk = ~clk;

  mdm_ctl_loop u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n),
    .dsr_n(dsr_n), .cts_n(cts_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .dsr(dsr), .cts(cts), .ri(ri), .dcd(dcd),
    .sin(sin), .sout(sout), .tx_shift(tx_shift), .rx_shift(rx_shift)
  );

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", req, what, got, exp, cycles);
    end
  endtask

  // compare all outputs against the model for the current register and pins
  task automatic compare_all();
    logic lp;
    lp = m_reg[4];
    chk(prev_wr ? "R2" : "R11", "rd_data", rd_data, m_reg);
    if (lp) begin
      chk("R10", "hs_out", {4'h0, dtr_n, rts_n, out1_n, out2_n}, 8'h0F);
      chk("R5",  "sout", {7'h0, sout}, 8'h01);
      chk("R7",  "rx_shift", {7'h0, rx_shift}, {7'h0, tx_shift});
      chk("R9",  "status", {4'h0, dcd, ri, cts, dsr}, {4'h0, m_reg[3:0]});
    end else begin
      chk("R3",  "dtr_n", {7'h0, dtr_n}, {7'h0, ~m_reg[0]});
      chk("R4",  "rts_n/out1_n/out2_n", {5'h0, out2_n, out1_n, rts_n},
          {5'h0, ~m_reg[3], ~m_reg[2], ~m_reg[1]});
      chk("R6",  "sout", {7'h0, sout}, {7'h0, tx_shift});
      chk("R6",  "rx_shift", {7'h0, rx_shift}, {7'h0, sin});
      chk("R8",  "status", {4'h0, dcd, ri, cts, dsr}, {4'h0, ~dcd_n, ~ri_n, ~cts_n, ~dsr_n});
    end
  endtask

  task automatic step(input logic we, input logic [7:0] d);
    @(negedge clk);
    cycles++;
    if (prev_wr) begin
      m_reg = 8'h00;
      for (int b = 0; b < 5; b++) m_reg[b] = prev_data[b];
    end
    compare_all();
    wr_en = we;
    wr_data = d;
    prev_wr = we;
    prev_data = d;
    {dsr_n, cts_n, ri_n, dcd_n} = 4'($urandom);
    sin = 1'($urandom);
    tx_shift = 1'($urandom);
    #1;
    compare_all();
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1", "rd_data in reset", rd_data, 8'h00);
    chk("R1", "hs_out in reset", {4'h0, dtr_n, rts_n, out1_n, out2_n}, 8'h0F);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rd_data after reset", rd_data, 8'h00);
    chk("R1", "loop off after reset", {7'h0, sout}, {7'h0, tx_shift});
    // directed corners
    step(1'b1, 8'hFF);   // all ones: upper field must read 0, loopback on
    step(1'b0, 8'h00);
    step(1'b0, 8'hAA);
    step(1'b1, 8'h0F);   // all handshakes active, no loop
    step(1'b0, 8'h00);
    step(1'b1, 8'hE0);   // only dead bits
    step(1'b0, 8'h00);
    step(1'b1, 8'h10);   // loop with handshakes off
    step(1'b0, 8'h00);
    step(1'b1, 8'h15);
    step(1'b0, 8'h00);
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 3) == 0, 8'($urandom));
    end
    step(1'b0, 8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule